// File: doc/BRIEF.md
# Instruction Decoder with Next-PC Unit

This block is the decode and control-flow stage of a 32-bit integer core. Each cycle it takes one fetched instruction word and the two register values read for it. It sorts the word into one of three encodings: register-register, register-immediate or long jump. It pulls out the register indices and the function field, and widens the immediate to the full word width. The immediate is sign-extended, except for unsigned arithmetic variants, where it is zero-extended.

From these it forms three results. The first is the second ALU operand. The second is the effective address for loads and stores. The third is the next program counter, which comes from a sequential step, a zero-test branch or a PC-relative jump.

The program counter register sits inside the block. It loads the next-PC value on every cycle in which the enable is high. An asynchronous active-low reset clears it to zero, and the reset is released through an internal two-flop synchronizer.

Top module: `idec_npc`

## Requirements
- R1: Opcode 0x00 (bits 31:26) is the register-register form: fmt=0, rs1_idx=bits 25:21, rs2_idx=bits 20:16, rd_idx=bits 15:11, func=bits 10:0, wr_en=1, imm=0, alu_b=rs2_val.
- R2: In the register-immediate form (fmt=1), rs1_idx=bits 25:21, bits 20:16 are the second register field and bits 15:0 the immediate; arithmetic and load write rd_idx=bits 20:16 with wr_en=1.
- R3: ADDI (0x08), SUBI (0x0A), LW (0x23), SW (0x2B), BEQZ (0x04) and BNEZ (0x05) sign-extend bits 15:0 into imm; for immediate forms alu_b=imm.
- R4: ADDUI (0x09) and SUBUI (0x0B) zero-extend bits 15:0 into imm and alu_b.
- R5: For LW and SW, eff_addr = rs1_val + sign-extended bits 15:0 (modulo 2^32); for every other instruction eff_addr=0.
- R6: SW sets rs2_idx=bits 20:16, st_data=rs2_val and wr_en=0; LW writes bits 20:16; st_data=0 for every non-store.
- R7: BEQZ is taken when rs1_val==0 and BNEZ when rs1_val!=0; a taken branch sets br_taken=1 and npc=pc+4+imm, otherwise npc=pc+4; branches never write (wr_en=0).
- R8: A branch ignores bits 20:16 and rs2_val: its npc and br_taken do not depend on them, and rs2_idx=0.
- R9: J (0x02) is fmt=2 with imm = sign-extended bits 25:0 and npc = pc+4+imm; wr_en=0.
- R10: Any other opcode sets illegal=1, fmt=3, imm=0, wr_en=0 and npc=pc+4.
- R11: An asynchronous low rst_n clears pc to 0 at once; after release, pc loads npc at each rising edge with en=1 and holds while en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Advance enable for the program counter |
| instr | input | 32 | Fetched instruction word |
| rs1_val | input | 32 | Value read from the first source register |
| rs2_val | input | 32 | Value read from the second source register |
| pc | output | 32 | Current program counter |
| npc | output | 32 | Next program counter |
| fmt | output | 2 | Encoding: 0 reg-reg, 1 reg-imm, 2 jump, 3 illegal |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Instruction writes a register |
| func | output | 11 | Function field of the reg-reg form |
| imm | output | 32 | Extended immediate |
| alu_b | output | 32 | Second ALU operand |
| eff_addr | output | 32 | Load/store effective address |
| is_load | output | 1 | Instruction is a load |
| is_store | output | 1 | Instruction is a store |
| st_data | output | 32 | Data to store |
| br_taken | output | 1 | Conditional branch taken |
| illegal | output | 1 | Opcode not recognised |

## Verification
The assertions assume that instr, rs1_val, rs2_val and en hold known values at every rising edge once the synchronized reset has been released. They also assume that en changes only between edges. The stimulus meets both assumptions: it drives all inputs from time zero, changes them only on falling edges, and keeps en low until a few cycles after reset. The checks on PC sequencing assume that the PC register is the only source of pc. The checks on branch direction assume that rs1_val is the condition operand.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int OPC_W  = 6;
  localparam int REG_W  = 5;
  localparam int FUNC_W = 11;
  localparam int IMM_W  = 16;
  localparam int OFF_W  = 26;

  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OPC_RR    = 6'h00;
  localparam opc_t OPC_J     = 6'h02;
  localparam opc_t OPC_BEQZ  = 6'h04;
  localparam opc_t OPC_BNEZ  = 6'h05;
  localparam opc_t OPC_ADDI  = 6'h08;
  localparam opc_t OPC_ADDUI = 6'h09;
  localparam opc_t OPC_SUBI  = 6'h0A;
  localparam opc_t OPC_SUBUI = 6'h0B;
  localparam opc_t OPC_LW    = 6'h23;
  localparam opc_t OPC_SW    = 6'h2B;

  typedef enum logic [1:0] {
    FMT_RR  = 2'd0,
    FMT_IMM = 2'd1,
    FMT_JMP = 2'd2,
    FMT_BAD = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    EXT_NONE = 2'd0,
    EXT_S16  = 2'd1,
    EXT_Z16  = 2'd2,
    EXT_S26  = 2'd3
  } ext_e;

  typedef struct packed {
    fmt_e fmt;
    ext_e ext;
    logic use_rs2;
    logic wr_en;
    logic rd_mid;
    logic is_load;
    logic is_store;
    logic is_branch;
    logic br_nez;
    logic is_jump;
    logic illegal;
  } dec_t;
endpackage

// File: rtl/idec_rst_sync.sv
module idec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/idec_classify.sv
module idec_classify
  import idec_pkg::*;
(
  input  opc_t opc,
  output dec_t dec
);
  always_comb begin
    dec           = '0;
    dec.fmt       = FMT_IMM;
    dec.ext       = EXT_S16;
    case (opc)
      OPC_RR: begin
        dec.fmt     = FMT_RR;
        dec.ext     = EXT_NONE;
        dec.use_rs2 = 1'b1;
        dec.wr_en   = 1'b1;
      end
      OPC_ADDI, OPC_SUBI: begin
        dec.wr_en  = 1'b1;
        dec.rd_mid = 1'b1;
      end
      OPC_ADDUI, OPC_SUBUI: begin
        dec.ext    = EXT_Z16;
        dec.wr_en  = 1'b1;
        dec.rd_mid = 1'b1;
      end
      OPC_LW: begin
        dec.wr_en   = 1'b1;
        dec.rd_mid  = 1'b1;
        dec.is_load = 1'b1;
      end
      OPC_SW: begin
        dec.is_store = 1'b1;
      end
      OPC_BEQZ: begin
        dec.is_branch = 1'b1;
      end
      OPC_BNEZ: begin
        dec.is_branch = 1'b1;
        dec.br_nez    = 1'b1;
      end
      OPC_J: begin
        dec.fmt     = FMT_JMP;
        dec.ext     = EXT_S26;
        dec.is_jump = 1'b1;
      end
      default: begin
        dec.fmt     = FMT_BAD;
        dec.ext     = EXT_NONE;
        dec.illegal = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/idec_imm_ext.sv
module idec_imm_ext
  import idec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OFF_W-1:0] raw,
  input  ext_e             sel,
  output logic [XLEN-1:0]  imm
);
  localparam int PAD16 = XLEN - IMM_W;
  localparam int PAD26 = XLEN - OFF_W;

  logic [XLEN-1:0] s16, z16, s26;

  always_comb begin
    s16 = {{PAD16{raw[IMM_W-1]}}, raw[IMM_W-1:0]};
    z16 = {{PAD16{1'b0}}, raw[IMM_W-1:0]};
    s26 = {{PAD26{raw[OFF_W-1]}}, raw};
  end

  always_comb begin
    case (sel)
      EXT_S16: imm = s16;
      EXT_Z16: imm = z16;
      EXT_S26: imm = s26;
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/idec_next_pc.sv
module idec_next_pc #(
  parameter int          XLEN     = 32,
  parameter int          STEP     = 4,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            is_branch,
  input  logic            br_nez,
  input  logic            is_jump,
  input  logic [XLEN-1:0] cond_val,
  input  logic [XLEN-1:0] imm,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] npc,
  output logic            br_taken
);
  localparam logic [XLEN-1:0] STEP_W = XLEN'(STEP);
  localparam logic [XLEN-1:0] RST_W  = XLEN'(RESET_PC);

  logic [XLEN-1:0] pc_q, pc_d, seq_pc, rel_pc;
  logic            cond_zero;

  always_comb begin
    seq_pc    = pc_q + STEP_W;
    rel_pc    = seq_pc + imm;
    cond_zero = (cond_val == '0);
    br_taken  = is_branch & (br_nez ? !cond_zero : cond_zero);
    npc       = (br_taken || is_jump) ? rel_pc : seq_pc;
    pc_d      = en ? npc : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_W;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pc)); // R11
  AST_PC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> pc == $past(npc)); // R11
  AST_BEQZ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !br_nez && cond_val != '0) |-> !br_taken); // R7
  AST_BNEZ_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && br_nez && cond_val != '0) |-> br_taken); // R7
  AST_NO_BRANCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_branch && !is_jump) |-> (npc == pc + STEP_W)); // R10
endmodule

// File: rtl/idec_npc.sv
module idec_npc
  import idec_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [31:0]         instr,
  input  logic [XLEN-1:0]     rs1_val,
  input  logic [XLEN-1:0]     rs2_val,
  output logic [XLEN-1:0]     pc,
  output logic [XLEN-1:0]     npc,
  output logic [1:0]          fmt,
  output logic [REG_W-1:0]    rs1_idx,
  output logic [REG_W-1:0]    rs2_idx,
  output logic [REG_W-1:0]    rd_idx,
  output logic                wr_en,
  output logic [FUNC_W-1:0]   func,
  output logic [XLEN-1:0]     imm,
  output logic [XLEN-1:0]     alu_b,
  output logic [XLEN-1:0]     eff_addr,
  output logic                is_load,
  output logic                is_store,
  output logic [XLEN-1:0]     st_data,
  output logic                br_taken,
  output logic                illegal
);
  localparam int RS1_LSB = OFF_W - REG_W;
  localparam int RS2_LSB = RS1_LSB - REG_W;
  localparam int RD_LSB  = RS2_LSB - REG_W;

  logic            rst_sync_n;
  dec_t            dec;
  logic            reg_form, imm_form, mem_op;
  logic [XLEN-1:0] imm_w;

  idec_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  idec_classify u_classify (
    .opc (instr[31:OFF_W]),
    .dec (dec)
  );

  idec_imm_ext #(.XLEN(XLEN)) u_imm_ext (
    .raw (instr[OFF_W-1:0]),
    .sel (dec.ext),
    .imm (imm_w)
  );

  idec_next_pc #(.XLEN(XLEN)) u_next_pc (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .is_branch (dec.is_branch),
    .br_nez    (dec.br_nez),
    .is_jump   (dec.is_jump),
    .cond_val  (rs1_val),
    .imm       (imm_w),
    .pc        (pc),
    .npc       (npc),
    .br_taken  (br_taken)
  );

  always_comb begin
    reg_form = (dec.fmt == FMT_RR);
    imm_form = (dec.fmt == FMT_IMM);
    mem_op   = dec.is_load | dec.is_store;
    fmt      = dec.fmt;
    wr_en    = dec.wr_en;
    illegal  = dec.illegal;
    is_load  = dec.is_load;
    is_store = dec.is_store;
    imm      = imm_w;
    rs1_idx  = (reg_form || imm_form) ? instr[OFF_W-1:RS1_LSB] : '0;
    rs2_idx  = (reg_form || dec.is_store) ? instr[RS1_LSB-1:RS2_LSB] : '0;
    if (!dec.wr_en)      rd_idx = '0;
    else if (dec.rd_mid) rd_idx = instr[RS1_LSB-1:RS2_LSB];
    else                 rd_idx = instr[RS2_LSB-1:RD_LSB];
    func     = reg_form ? instr[FUNC_W-1:0] : '0;
    alu_b    = dec.use_rs2 ? rs2_val : imm_w;
    eff_addr = mem_op ? (rs1_val + imm_w) : '0;
    st_data  = dec.is_store ? rs2_val : '0;
  end

  AST_EA_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(is_load || is_store) |-> (eff_addr == '0)); // R5
  AST_ST_NOWRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_store |-> !wr_en); // R6
  AST_ILLEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal |-> (!wr_en && npc == pc + XLEN'(4) && imm == '0)); // R10
  AST_BR_NOWRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    br_taken |-> (!wr_en && rs2_idx == '0)); // R8
  AST_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({is_load, is_store, illegal, br_taken})); // R10
  AST_JMP_REL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fmt == 2'd2) |-> (npc == pc + XLEN'(4) + imm)); // R9
endmodule

// File: tb/idec_npc_bench.sv
module idec_npc_bench;
  localparam int CLK_P = 20;
  localparam int NV    = 14;

  typedef struct packed {
    logic [31:0] ins, a, b;
    logic [1:0]  fmt;
    logic [31:0] imm, alub, off, ea;
    logic        wr;
    logic [4:0]  rd;
    logic        ill, tk;
  } vec_t;

  localparam vec_t VECS [0:NV-1] = '{
    '{32'h00642820, 32'h11,   32'h22, 2'd0, 32'h0,        32'h22,       32'h4,        32'h0,    1'b1, 5'd5, 1'b0, 1'b0},
    '{32'h2022FFFC, 32'h0,    32'h0,  2'd1, 32'hFFFFFFFC, 32'hFFFFFFFC, 32'h4,        32'h0,    1'b1, 5'd2, 1'b0, 1'b0},
    '{32'h2422FFFC, 32'h0,    32'h0,  2'd1, 32'h0000FFFC, 32'h0000FFFC, 32'h4,        32'h0,    1'b1, 5'd2, 1'b0, 1'b0},
    '{32'h28E88000, 32'h0,    32'h0,  2'd1, 32'hFFFF8000, 32'hFFFF8000, 32'h4,        32'h0,    1'b1, 5'd8, 1'b0, 1'b0},
    '{32'h2CE88000, 32'h0,    32'h0,  2'd1, 32'h00008000, 32'h00008000, 32'h4,        32'h0,    1'b1, 5'd8, 1'b0, 1'b0},
    '{32'h8C49FFF0, 32'h1000, 32'h0,  2'd1, 32'hFFFFFFF0, 32'hFFFFFFF0, 32'h4,        32'h0FF0, 1'b1, 5'd9, 1'b0, 1'b0},
    '{32'hAC490010, 32'h1000, 32'h77, 2'd1, 32'h10,       32'h10,       32'h4,        32'h1010, 1'b0, 5'd0, 1'b0, 1'b0},
    '{32'h10DF0020, 32'h0,    32'h0,  2'd1, 32'h20,       32'h20,       32'h24,       32'h0,    1'b0, 5'd0, 1'b0, 1'b1},
    '{32'h10DF0020, 32'h5,    32'h0,  2'd1, 32'h20,       32'h20,       32'h4,        32'h0,    1'b0, 5'd0, 1'b0, 1'b0},
    '{32'h14DFFFF8, 32'h1,    32'h0,  2'd1, 32'hFFFFFFF8, 32'hFFFFFFF8, 32'hFFFFFFFC, 32'h0,    1'b0, 5'd0, 1'b0, 1'b1},
    '{32'h14DFFFF8, 32'h0,    32'h0,  2'd1, 32'hFFFFFFF8, 32'hFFFFFFF8, 32'h4,        32'h0,    1'b0, 5'd0, 1'b0, 1'b0},
    '{32'h08000100, 32'h0,    32'h0,  2'd2, 32'h100,      32'h100,      32'h104,      32'h0,    1'b0, 5'd0, 1'b0, 1'b0},
    '{32'h0BFFFFF0, 32'h0,    32'h0,  2'd2, 32'hFFFFFFF0, 32'hFFFFFFF0, 32'hFFFFFFF4, 32'h0,    1'b0, 5'd0, 1'b0, 1'b0},
    '{32'hFC001234, 32'h0,    32'h0,  2'd3, 32'h0,        32'h0,        32'h4,        32'h0,    1'b0, 5'd0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [31:0] instr, rs1_val, rs2_val;
  logic [31:0] pc, npc, imm, alu_b, eff_addr, st_data;
  logic [1:0]  fmt;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [10:0] func;
  logic        wr_en, is_load, is_store, br_taken, illegal;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc, npc_ref;

  always #(CLK_P/2) clk = ~clk;

  idec_npc u_idec_npc (
    .clk(clk), .rst_n(rst_n), .en(en), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc), .npc(npc),
    .fmt(fmt), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
    .wr_en(wr_en), .func(func), .imm(imm), .alu_b(alu_b),
    .eff_addr(eff_addr), .is_load(is_load), .is_store(is_store),
    .st_data(st_data), .br_taken(br_taken), .illegal(illegal)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0:        return "R1";
      1, 3:     return "R3";
      2, 4:     return "R4";
      5:        return "R5";
      6:        return "R6";
      7,8,9,10: return "R7";
      11, 12:   return "R9";
      default:  return "R10";
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0;
    instr = 32'h0; rs1_val = 32'h0; rs2_val = 32'h0;
    repeat (3) @(negedge clk);
    chk("R11", "pc in reset", pc, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "pc after reset", pc, 32'h0);
    exp_pc = 32'h0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = VECS[i].ins; rs1_val = VECS[i].a; rs2_val = VECS[i].b; en = 1'b1;
      #2;
      chk(tag_of(i), "fmt", {30'h0, fmt}, {30'h0, VECS[i].fmt});
      chk(tag_of(i), "imm", imm, VECS[i].imm);
      chk(tag_of(i), "alu_b", alu_b, VECS[i].alub);
      chk(tag_of(i), "npc-pc", npc - pc, VECS[i].off);
      chk(tag_of(i), "eff_addr", eff_addr, VECS[i].ea);
      chk(tag_of(i), "wr_en", {31'h0, wr_en}, {31'h0, VECS[i].wr});
      chk((VECS[i].fmt == 2'd1 && VECS[i].wr) ? "R2" : tag_of(i), "rd_idx",
          {27'h0, rd_idx}, {27'h0, VECS[i].rd});
      chk(tag_of(i), "illegal", {31'h0, illegal}, {31'h0, VECS[i].ill});
      chk(tag_of(i), "br_taken", {31'h0, br_taken}, {31'h0, VECS[i].tk});
      @(posedge clk);
      #1;
      exp_pc = exp_pc + VECS[i].off;
      chk("R11", "pc advance", pc, exp_pc);
    end

    // R1 / R2: field positions
    @(negedge clk);
    en = 1'b0; instr = 32'h00642820; rs1_val = 32'h0; rs2_val = 32'h0;
    #2;
    chk("R1", "func", {21'h0, func}, 32'h20);
    chk("R1", "rs1_idx", {27'h0, rs1_idx}, 32'd3);
    chk("R1", "rs2_idx", {27'h0, rs2_idx}, 32'd4);
    instr = 32'h28E88000;
    #2;
    chk("R2", "rs1_idx", {27'h0, rs1_idx}, 32'd7);
    chk("R2", "func zero", {21'h0, func}, 32'h0);

    // R6: store data path and load destination
    instr = 32'hAC490010; rs2_val = 32'hCAFEF00D; rs1_val = 32'h2000;
    #2;
    chk("R6", "st_data", st_data, 32'hCAFEF00D);
    chk("R6", "rs2_idx store", {27'h0, rs2_idx}, 32'd9);
    chk("R6", "is_store", {31'h0, is_store}, 32'h1);
    instr = 32'h8C49FFF0;
    #2;
    chk("R6", "st_data on load", st_data, 32'h0);
    chk("R6", "is_load", {31'h0, is_load}, 32'h1);

    // R8: branch ignores second field and rs2_val
    instr = 32'h10C00020; rs1_val = 32'h0; rs2_val = 32'hDEAD;
    #2;
    npc_ref = npc;
    chk("R8", "npc taken", npc_ref, pc + 32'h24);
    instr = 32'h10DF0020; rs2_val = 32'h1234;
    #2;
    chk("R8", "npc unchanged", npc, npc_ref);
    chk("R8", "br_taken", {31'h0, br_taken}, 32'h1);
    chk("R8", "rs2_idx", {27'h0, rs2_idx}, 32'h0);

    // R11: hold with en low
    npc_ref = pc;
    @(posedge clk);
    #1;
    chk("R11", "pc hold", pc, npc_ref);

    // R11: asynchronous reset mid-run
    #4;
    rst_n = 1'b0;
    #1;
    chk("R11", "async clear", pc, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "pc after re-reset", pc, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule